// File: doc/BRIEF.md
# SPI Master With Per-Word Command Control

This block is an SPI bus master that takes a stream of 32-bit command words over a ready/valid input. Every command word carries up to 16 payload bits and also says how to send them: the bit count, which of four slave selects to drive, whether the selects drop after this word, whether an idle gap follows, and whether the bits clocked in from the slave should be kept. The engine shifts the payload out MSB-first in SPI mode 0 and assembles the returning bits. Kept words appear on a ready/valid receive port.

Words longer than 16 bits are sent as several commands that leave the release flag clear, so the selects stay low across the whole burst. The serial clock rate and the two gap lengths come from static inputs. The select polarity can be inverted per line. Receive back-pressure stalls the command port only for words that want their received bits kept.

Top module: `spi_word_master`

Command word layout (bit positions are fixed): data `[15:0]`, select controls `[19:16]` (bit 16+i drives select i, 0 = assert, 1 = leave released), release-after flag `[20]`, frame-gap flag `[21]`, drop-receive flag `[22]`, length code `[27:24]`. Bits 23 and 31:28 are ignored.

## Requirements
- R1: A command with length code L (bits 27:24) sends exactly L+1 bits on `mosi_o`, MSB-first, starting at data bit L (bits 15:0) and ending at data bit 0.
- R2: `sck_o` idles low while no word is shifting. Each high or low phase lasts `div_i`+1 clock cycles. `mosi_o` changes only when `sck_o` falls. `miso_i` is sampled when `sck_o` rises.
- R3: A kept word's received bits are presented right-aligned on `rx_data_o` (first received bit in position L). `rx_last_o` copies bit 20 of the command that produced it. Both hold steady while `rx_valid_o` is high and `rx_ready_i` is low.
- R4: Select i is asserted during a word when command bit 16+i is 0. The level on `cs_o[i]` is low for an asserted select when `cs_pol_i[i]`=0 and high when it is 1. A released select drives the inverse level.
- R5: When bit 20 is set, all selects are released after the word's last bit. They stay released for at least `xfer_gap_i`+1 cycles, exactly that many when the next command is already waiting.
- R6: When bit 21 is set, `sck_o` stays low for `frame_gap_i` extra cycles before the next word's first rising edge, and the selects do not change. Without bit 21, the low time between back-to-back words is `div_i`+2 cycles.
- R7: Words sent back to back with bit 20 clear and the same select pattern keep the selects asserted, with no change on `cs_o` between the first and the last word.
- R8: A command with bit 22 clear is not accepted (`cmd_ready_o` low, no `sck_o` activity) while a received word is still unread. It is accepted in the cycle after the word is read.
- R9: A command with bit 22 set is accepted even when the receive holding register is full. It captures nothing, so `rx_valid_o`, `rx_data_o` and `rx_last_o` keep their previous state.
- R10: When a new command's select pattern differs from the one currently asserted, the current selects are released for exactly `xfer_gap_i`+1 cycles before the new pattern is asserted and shifting starts.
- R11: After reset, all selects are released, `sck_o` and `mosi_o` are low, `rx_valid_o` is low and `cmd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word offered |
| cmd_ready_o | output | 1 | Command word taken this cycle when valid |
| cmd_word_i | input | 32 | Command word (layout above) |
| div_i | input | DIV_W | SCK half-period minus one, in clock cycles |
| xfer_gap_i | input | GAP_W | Minimum select-release time minus one |
| frame_gap_i | input | GAP_W | Extra idle cycles after a frame-gap word |
| cs_pol_i | input | 4 | Per-select polarity, 0 = active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Slave select lines |
| rx_valid_o | output | 1 | Received word held |
| rx_ready_i | input | 1 | Consumer takes the received word |
| rx_data_o | output | 16 | Received bits, right-aligned |
| rx_last_o | output | 1 | Release flag of the producing command |

## Verification
The bench sweeps every length code at two divider settings with varied payloads and slave patterns. An off-by-one in the start bit or in the bit count would show up as a wrong shifted or received value, and a divider error would show up as wrong high-phase cycle counts.

It measures the select-release time after a release-flag word and after a pattern change, including a zero transfer gap. A design that started the next word early, or skipped the release on a pattern change, would produce a short release or the wrong number of select edges.

It fills the receive register and then offers a dropped-receive word followed by a kept one. A design that stalled the dropped word, overwrote held data, or let the kept word start while data was unread would lose data or hang the command port. It also times the serial-clock low gap with and without the frame flag, and checks inverted select polarity.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_CS  = 4;
  localparam int unsigned LEN_W   = $clog2(DATA_W);
  localparam int unsigned CMD_W   = 32;
  localparam int unsigned SPARE_W = CMD_W - DATA_W - NUM_CS - 4 - LEN_W;

  // field order fixed by the command layout
  typedef struct packed {
    logic [SPARE_W-1:0] spare_hi;
    logic [LEN_W-1:0]   len;
    logic               spare_mid;
    logic               rx_skip;
    logic               frame_end;
    logic               xfer_end;
    logic [NUM_CS-1:0]  sel_n;
    logic [DATA_W-1:0]  data;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE_GAP,
    ST_SHIFT,
    ST_POST_GAP
  } st_e;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              last_o
);
  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;
  logic [LEN_W-1:0]  left_q;

  assign mosi_o    = tx_sr_q[DATA_W-1];
  assign rx_word_o = rx_sr_q;
  assign last_o    = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      left_q  <= '0;
    end else if (load_i) begin
      // align bit len_i to the MSB so it leaves first
      tx_sr_q <= data_i << (LEN_W'(DATA_W-1) - len_i);
      rx_sr_q <= '0;
      left_q  <= len_i;
    end else begin
      if (rise_i) rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso_i};
      if (fall_i && !last_o) begin
        tx_sr_q <= tx_sr_q << 1;
        left_q  <= left_q - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              last_q;

  assign valid_o = full_q;
  assign data_o  = data_q;
  assign last_o  = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (push_i) begin
      full_q <= 1'b1;
      data_q <= data_i;
      last_q <= last_i;
    end else if (full_q && ready_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned GAP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [GAP_W-1:0]  xfer_gap_i,
  input  logic [GAP_W-1:0]  frame_gap_i,
  input  logic [NUM_CS-1:0] cs_pol_i,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_last_o
);
  localparam int unsigned CNT_W = GAP_W + 1;

  cmd_t              cmd_in, cur_q, load_cmd;
  st_e               st_q;
  logic [NUM_CS-1:0] cs_act_q, new_sel;
  logic [CNT_W-1:0]  gap_q, post_sum;
  logic              sck_q, shifting, tick, rise, fall, word_done;
  logic              accept, need_release, load, last_bit, sh_mosi, rx_push, cur_skip;
  logic [DATA_W-1:0] rx_word;
  logic              unused_spare;

  assign cmd_in       = cmd_t'(cmd_word_i);
  assign unused_spare = ^{cmd_in.spare_hi, cmd_in.spare_mid, cur_q.spare_hi, cur_q.spare_mid};
  assign new_sel      = ~cmd_in.sel_n;
  assign shifting     = (st_q == ST_SHIFT);
  assign cur_skip     = cur_q.rx_skip;

  // kept words wait for the holding register; dropped words never do
  assign cmd_ready_o  = (st_q == ST_IDLE) && (!rx_valid_o || cmd_in.rx_skip);
  assign accept       = cmd_valid_i && cmd_ready_o;
  assign need_release = (cs_act_q != '0) && (cs_act_q != new_sel);
  assign load         = (accept && !need_release) ||
                        ((st_q == ST_PRE_GAP) && (gap_q == '0));
  assign load_cmd     = accept ? cmd_in : cur_q;

  assign rise      = tick && !sck_q;
  assign fall      = tick && sck_q;
  assign word_done = fall && last_bit;
  assign rx_push   = word_done && !cur_q.rx_skip;
  assign post_sum  = (cur_q.xfer_end  ? CNT_W'(xfer_gap_i)  : '0) +
                     (cur_q.frame_end ? CNT_W'(frame_gap_i) : '0);

  spi_sck_div #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (shifting),
    .div_i  (div_i),
    .tick_o (tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (load_cmd.data),
    .len_i     (load_cmd.len),
    .rise_i    (rise),
    .fall_i    (fall),
    .miso_i    (miso_i),
    .mosi_o    (sh_mosi),
    .rx_word_o (rx_word),
    .last_o    (last_bit)
  );

  spi_rx_hold #(.DATA_W(DATA_W)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_word),
    .last_i  (cur_q.xfer_end),
    .ready_i (rx_ready_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .last_o  (rx_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sck_q <= 1'b0;
    else if (shifting && tick)  sck_q <= ~sck_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      cs_act_q <= '0;
      gap_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            cur_q <= cmd_in;
            if (need_release) begin
              cs_act_q <= '0;
              gap_q    <= CNT_W'(xfer_gap_i);
              st_q     <= ST_PRE_GAP;
            end else begin
              cs_act_q <= new_sel;
              st_q     <= ST_SHIFT;
            end
          end
        end
        ST_PRE_GAP: begin
          if (gap_q == '0) begin
            cs_act_q <= ~cur_q.sel_n;
            st_q     <= ST_SHIFT;
          end else begin
            gap_q <= gap_q - CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (word_done) begin
            if (cur_q.xfer_end) cs_act_q <= '0;
            if (post_sum == '0) begin
              st_q <= ST_IDLE;
            end else begin
              gap_q <= post_sum - CNT_W'(1);
              st_q  <= ST_POST_GAP;
            end
          end
        end
        default: begin
          if (gap_q == '0) st_q <= ST_IDLE;
          else             gap_q <= gap_q - CNT_W'(1);
        end
      endcase
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = shifting && sh_mosi;
  assign cs_o   = ~cs_act_q ^ cs_pol_i;
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk
  import spi_word_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sck_i,
  input logic              mosi_i,
  input logic [NUM_CS-1:0] cs_i,
  input logic              shifting_i,
  input logic              push_i,
  input logic              skip_i,
  input logic              rx_valid_i,
  input logic              rx_ready_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              rx_last_i,
  input logic              cmd_ready_i
);
  assert_sck_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shifting_i |-> !sck_i);

  assert_mosi_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shifting_i && $past(shifting_i) && !$stable(mosi_i)) |-> $fell(sck_i));

  assert_cs_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shifting_i && $past(shifting_i)) |-> $stable(cs_i));

  assert_rx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_ready_i) |=> (rx_valid_i && $stable(rx_data_i) && $stable(rx_last_i)));

  assert_no_overwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !rx_valid_i);

  assert_ready_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_i |-> !shifting_i);

  assert_skip_no_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !skip_i);
endmodule

bind spi_word_master spi_word_master_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sck_i       (sck_o),
  .mosi_i      (mosi_o),
  .cs_i        (cs_o),
  .shifting_i  (shifting),
  .push_i      (rx_push),
  .skip_i      (cur_skip),
  .rx_valid_i  (rx_valid_o),
  .rx_ready_i  (rx_ready_i),
  .rx_data_i   (rx_data_o),
  .rx_last_i   (rx_last_o),
  .cmd_ready_i (cmd_ready_o)
);

// File: tb/test_spi_word_master.sv
module test_spi_word_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic [7:0]  div = '0, xgap = 8'd7, fgap = 8'd5;
  logic [3:0]  pol = '0;
  logic        sck, mosi, miso = 1'b0;
  logic [3:0]  cs;
  logic        rx_valid, rx_ready = 1'b0, rx_last;
  logic [15:0] rx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // monitor state
  logic [15:0] mon_bits, m_slv;
  logic [3:0]  mon_cs, cs_prev;
  logic        sck_prev;
  int mon_rises, mon_high, cs_changes, low_run, probe_low, probe_at, rel_run, last_rel, m_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_word_master i_spi_word_master (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_word_i(cmd_word),
    .div_i(div), .xfer_gap_i(xgap), .frame_gap_i(fgap), .cs_pol_i(pol),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_o(cs),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data), .rx_last_o(rx_last)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int len, logic [3:0] sel_n, bit eot, bit eof, bit skip,
                                     logic [15:0] d);
    return (32'(len) << 24) | (32'(skip) << 22) | (32'(eof) << 21) | (32'(eot) << 20) |
           (32'(sel_n) << 16) | 32'(d);
  endfunction

  function automatic logic [15:0] mask(int len);
    return 16'((32'd1 << (len + 1)) - 1);
  endfunction

  task automatic reset_mon(int len, logic [15:0] slv);
    mon_bits = '0; mon_rises = 0; mon_high = 0; cs_changes = 0;
    m_len = len; m_slv = slv; miso = slv[len];
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sck) mon_high++;
      if (sck && !sck_prev) begin
        mon_bits = {mon_bits[14:0], mosi};
        mon_rises++;
        if (mon_rises == 1) mon_cs = cs;
        if (mon_rises == probe_at) probe_low = low_run;
        low_run = 0;
        miso = (m_len - mon_rises >= 0) ? m_slv[m_len - mon_rises] : 1'b0;
      end else if (!sck) begin
        low_run++;
      end
      if (cs != cs_prev) cs_changes++;
      if (cs == ~pol) rel_run++;
      else begin
        if (rel_run != 0) last_rel = rel_run;
        rel_run = 0;
      end
    end
    sck_prev = sck;
    cs_prev  = cs;
  end

  task automatic send(input string req, input logic [31:0] w);
    int t;
    @(negedge clk);
    cmd_word = w; cmd_valid = 1'b1;
    #1;
    t = 0;
    while (!cmd_ready && t < 2000) begin @(negedge clk); #1; t++; end
    chk({req, " command accepted"}, 32'(cmd_ready), 32'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic pop(input string req, input logic [15:0] d, input bit last);
    @(negedge clk);
    chk({req, " rx_valid"}, 32'(rx_valid), 32'd1);
    chk({req, " rx_data"}, 32'(rx_data), 32'(d));
    chk({req, " rx_last"}, 32'(rx_last), 32'(last));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk({req, " rx drained"}, 32'(rx_valid), 32'd0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, s, da, sa;
    int h;
    sck_prev = 1'b0; cs_prev = 4'hF; low_run = 0; rel_run = 0; last_rel = 0;
    probe_at = -1; probe_low = 0; mon_cs = '0;
    reset_mon(0, '0);
    idle(3);
    #1;
    // R11 reset state
    chk("R11 cs released", 32'(cs), 32'hF);
    chk("R11 sck low", 32'(sck), 32'd0);
    chk("R11 mosi low", 32'(mosi), 32'd0);
    chk("R11 rx_valid low", 32'(rx_valid), 32'd0);
    chk("R11 cmd_ready high", 32'(cmd_ready), 32'd1);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3 R4: sweep lengths, dividers and patterns
    for (int dv = 0; dv < 2; dv++) begin
      div = (dv == 0) ? 8'd0 : 8'd2;
      h = int'(div) + 1;
      for (int len = 0; len < 16; len++) begin
        for (int p = 0; p < 3; p++) begin
          d = 16'((len + 1 + p * 17) * 32'h9E37);
          s = ~d ^ 16'(len << 3) ^ 16'(p * 16'h0F0F);
          reset_mon(len, s);
          send("R1", mk(len, 4'b1110, len[0], 1'b0, 1'b0, d));
          idle(2 * (len + 1) * h + 4);
          chk("R1 bit count", 32'(mon_rises), 32'(len + 1));
          chk("R1 shifted bits", 32'(mon_bits & mask(len)), 32'(d & mask(len)));
          chk("R2 high cycles", 32'(mon_high), 32'((len + 1) * h));
          chk("R4 select level", 32'(mon_cs), 32'b1110);
          pop("R3", s & mask(len), len[0]);
        end
      end
    end

    div = 8'd1; h = 2;
    // R4 inverted polarity
    idle(20);
    pol = 4'b0101;
    idle(2);
    chk("R4 released level inverted", 32'(cs), 32'b1010);
    reset_mon(3, 16'h0);
    send("R4", mk(3, 4'b0011, 1'b1, 1'b0, 1'b1, 16'h000B));
    idle(30);
    chk("R4 asserted level inverted", 32'(mon_cs), 32'b0110);
    chk("R4 released after word", 32'(cs), 32'b1010);
    pol = 4'b0000;
    idle(2);

    // R7 and R6 baseline: back to back without release
    reset_mon(9, 16'h0);
    probe_at = 11;
    send("R7", mk(9, 4'b1101, 1'b0, 1'b0, 1'b1, 16'h02C5));
    send("R7", mk(4, 4'b1101, 1'b1, 1'b0, 1'b1, 16'h0013));
    idle(60);
    chk("R7 total bits", 32'(mon_rises), 32'd15);
    chk("R7 joined bits", 32'(mon_bits & 16'h7FFF), 32'({10'h2C5, 5'h13}));
    chk("R7 select edges", 32'(cs_changes), 32'd2);
    chk("R6 low time without frame flag", 32'(probe_low), 32'(h + 1));
    chk("R9 nothing captured", 32'(rx_valid), 32'd0);

    // R6 frame gap
    reset_mon(5, 16'h0);
    probe_at = 7;
    send("R6", mk(5, 4'b1101, 1'b0, 1'b1, 1'b1, 16'h0015));
    send("R6", mk(2, 4'b1101, 1'b1, 1'b0, 1'b1, 16'h0005));
    idle(60);
    chk("R6 low time with frame flag", 32'(probe_low), 32'(int'(fgap) + h + 1));
    chk("R6 selects held", 32'(cs_changes), 32'd2);
    probe_at = -1;

    // R5 release after word
    reset_mon(3, 16'h0);
    send("R5", mk(3, 4'b1011, 1'b1, 1'b0, 1'b1, 16'h0009));
    send("R5", mk(3, 4'b1011, 1'b1, 1'b0, 1'b1, 16'h0006));
    idle(40);
    chk("R5 release time", 32'(last_rel), 32'(int'(xgap) + 1));
    chk("R5 select edges", 32'(cs_changes), 32'd4);

    // R10 pattern change, with and without a transfer gap
    for (int g = 0; g < 2; g++) begin
      xgap = (g == 0) ? 8'd7 : 8'd0;
      idle(20);
      reset_mon(2, 16'h0);
      send("R10", mk(2, 4'b1110, 1'b0, 1'b0, 1'b1, 16'h0003));
      send("R10", mk(2, 4'b0111, 1'b1, 1'b0, 1'b1, 16'h0004));
      idle(40);
      chk("R10 release time", 32'(last_rel), 32'(int'(xgap) + 1));
      chk("R10 select edges", 32'(cs_changes), 32'd4);
      chk("R10 bits sent", 32'(mon_rises), 32'd6);
    end
    xgap = 8'd7;

    // R8 R9: full holding register
    da = 16'h00A7; sa = 16'h005C;
    reset_mon(7, sa);
    send("R8", mk(7, 4'b1110, 1'b1, 1'b0, 1'b0, da));
    idle(60);
    reset_mon(4, 16'h001F);
    send("R9", mk(4, 4'b1110, 1'b0, 1'b0, 1'b1, 16'h0011));
    idle(40);
    chk("R9 dropped word still sent", 32'(mon_rises), 32'd5);
    chk("R9 holding register kept", 32'(rx_data), 32'(sa));
    chk("R9 holding valid kept", 32'(rx_valid), 32'd1);
    chk("R9 holding flag kept", 32'(rx_last), 32'd1);
    reset_mon(5, 16'h002D);
    @(negedge clk);
    cmd_word = mk(5, 4'b1110, 1'b1, 1'b0, 1'b0, 16'h0031); cmd_valid = 1'b1;
    idle(50);
    #1;
    chk("R8 stalled while unread", 32'(cmd_ready), 32'd0);
    chk("R8 no clocks while stalled", 32'(mon_rises), 32'd0);
    pop("R8", sa, 1'b1);
    #1;
    chk("R8 ready after read", 32'(cmd_ready), 32'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    idle(40);
    chk("R8 resumed word bits", 32'(mon_bits & mask(5)), 32'h31);
    pop("R8 resumed", 16'h002D, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule